// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-facing register bank in front of the translation entry storage. A processor reaches it over a simple register bus: a register number, a write strobe, a read strobe and 32-bit data. An index register picks one entry. Two access windows read and write that entry's tag word and data word. A process ID register is stamped into each entry as its translation ID when the tag is written. A zone protection register is passed on to the lookup unit. A write-only search register asks the external lookup unit to find an entry for a page.

The bank holds the tag, data and translation-ID arrays and exports them flat to the lookup unit. It raises a per-entry invalidate mask whenever a cached translation may have become stale. While a search is out, the bus is stalled through a ready output. Address translation and cache flushing are done by neighbouring logic.

Register numbers on `regSel`: 0 index, 1 process ID, 2 zone, 3 tag window, 4 data window, 5 search. Numbers 6 and 7 are unused.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset every register reads 0 and every entry holds zeros. `ready` is 1, `srchReq` is 0 and `invalMask` is 0.
- R2: A write to register 0 updates index bits [30:0] and leaves bit 31, the miss flag, unchanged. The selected entry is given by the low log2(ENTRIES) index bits, which is bits [3:0] at the default of 16 entries.
- R3: Writes to register 3 or register 4 store the word in the selected entry's tag or data array. Reads of those registers return the stored word.
- R4: The process ID register keeps only bits [7:0] of a write and reads back zero-extended. A tag write stores the current process ID as the entry's translation ID.
- R5: In the cycle a tag write is accepted, `invalMask` has exactly the selected entry's bit set if the entry's old tag is valid (tag bit 6 set). Otherwise `invalMask` is 0.
- R6: A read of register 3 loads the process ID register with the selected entry's translation ID.
- R7: An accepted write to register 5 raises `srchReq` from the next cycle. The lookup address is the written value with bits [9:0] cleared, and it is held steady. `ready` is 0 from the next cycle until the cycle after `srchDone`, and bus accesses are not accepted meanwhile.
- R8: On `srchDone` with `srchHit` = 1, the whole index register becomes `srchIdx` zero-extended, which clears the miss flag. With `srchHit` = 0, only index bit 31 is set.
- R9: Register 5 and unused registers 6 and 7 read as 0. Writes to registers 6 and 7 change nothing.
- R10: Parameter ACCESS: bit 0 permits reads of registers 1 to 4, and bit 1 permits writes to registers 1, 2 and 5. A denied read returns 0 and a denied write has no effect. Register 0 and the window writes need only a nonzero ACCESS.
- R11: In the cycle a process ID write that changes bits [7:0] is accepted, `invalMask` flags every valid entry whose nonzero translation ID equals the old process ID. Any other accepted write (except a tag write), and any accepted read, leaves `invalMask` at 0.
- R12: The zone register stores and reads back all 32 bits and drives `zoneOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 3 | Register number |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of an accepted read |
| ready | output | 1 | Bus may complete an access this cycle |
| srchReq | output | 1 | Search request to the lookup unit |
| srchAddr | output | 32 | Page address for the search |
| srchDone | input | 1 | Lookup finished |
| srchHit | input | 1 | Lookup found an entry |
| srchIdx | input | IDX_W | Index of the entry found |
| invalMask | output | ENTRIES | Per-entry invalidate notification |
| pidOut | output | TID_W | Current process ID |
| zoneOut | output | 32 | Zone protection word |
| tagFlat | output | ENTRIES*32 | All tag words, entry e at bits [e*32 +: 32] |
| dataFlat | output | ENTRIES*32 | All data words |
| tidFlat | output | ENTRIES*TID_W | All translation IDs |

## Verification
Read data and `invalMask` are combinational in the cycle that accepts the access. The bench drives each access at a falling edge and samples those outputs 1 ns later, before the rising edge that commits the access. Register contents appear after that edge, so they are checked by a read issued one cycle later. For the process ID, that read comes after the tag read whose side effect it checks. After a search write, `ready` and `srchReq` are checked at the next falling edge and at every falling edge of the stall. The index register is read back only after `ready` has returned, which is the falling edge after the `srchDone` cycle.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;
  localparam int DW = 32;

  localparam logic [2:0] SEL_INDEX  = 3'd0;
  localparam logic [2:0] SEL_PID    = 3'd1;
  localparam logic [2:0] SEL_ZONE   = 3'd2;
  localparam logic [2:0] SEL_TAG    = 3'd3;
  localparam logic [2:0] SEL_DATA   = 3'd4;
  localparam logic [2:0] SEL_SEARCH = 3'd5;

  typedef struct packed {
    logic idxWr;
    logic pidWr;
    logic zoneWr;
    logic tagWr;
    logic dataWr;
    logic tagRd;
    logic srchGo;
    logic srchEnd;
    logic rdOk;
  } strobes_t;
endpackage

// File: rtl/tlb_mgmt_ctrl.sv
module tlb_mgmt_ctrl
  import tlb_mgmt_pkg::*;
#(
  parameter int ACCESS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] regSel,
  input  logic       srchDone,
  output logic       ready,
  output logic       pending,
  output strobes_t   strb
);
  localparam bit ANY_OK  = ACCESS != 0;
  localparam bit READ_OK = (ACCESS & 1) != 0;
  localparam bit FULL_OK = (ACCESS & 2) != 0;

  logic pendQ;
  logic wrAcc;
  logic rdAcc;

  assign ready   = ~pendQ;
  assign pending = pendQ;
  assign wrAcc   = wrEn & ~pendQ;
  assign rdAcc   = rdEn & ~wrEn & ~pendQ;

  always_comb begin
    strb = '0;
    strb.srchEnd = pendQ & srchDone;
    if (wrAcc) begin
      case (regSel)
        SEL_INDEX:  strb.idxWr  = ANY_OK;
        SEL_PID:    strb.pidWr  = FULL_OK;
        SEL_ZONE:   strb.zoneWr = FULL_OK;
        SEL_TAG:    strb.tagWr  = ANY_OK;
        SEL_DATA:   strb.dataWr = ANY_OK;
        SEL_SEARCH: strb.srchGo = FULL_OK;
        default: ;
      endcase
    end
    if (rdAcc) begin
      case (regSel)
        SEL_INDEX: strb.rdOk = ANY_OK;
        SEL_PID, SEL_ZONE, SEL_DATA: strb.rdOk = READ_OK;
        SEL_TAG: begin
          strb.rdOk  = READ_OK;
          strb.tagRd = READ_OK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pendQ <= 1'b0;
    else if (strb.srchGo) pendQ <= 1'b1;
    else if (strb.srchEnd) pendQ <= 1'b0;
  end
endmodule

// File: rtl/tlb_mgmt_dp.sv
module tlb_mgmt_dp
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int TID_W     = 8,
  parameter int PAGE_LSB  = 10,
  parameter int VALID_BIT = 6,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobes_t                 strb,
  input  logic [2:0]               regSel,
  input  logic [DW-1:0]            wrData,
  input  logic                     srchHit,
  input  logic [IDX_W-1:0]         srchIdx,
  output logic [DW-1:0]            rdData,
  output logic [DW-1:0]            srchAddr,
  output logic [DW-1:0]            indexQ,
  output logic [ENTRIES-1:0]       invalMask,
  output logic [TID_W-1:0]         pidOut,
  output logic [DW-1:0]            zoneOut,
  output logic [ENTRIES*DW-1:0]    tagFlat,
  output logic [ENTRIES*DW-1:0]    dataFlat,
  output logic [ENTRIES*TID_W-1:0] tidFlat
);
  localparam logic [DW-1:0] PAGE_MASK = ~((DW'(1) << PAGE_LSB) - DW'(1));

  logic [DW-1:0]    idxQ;
  logic [TID_W-1:0] pidQ;
  logic [DW-1:0]    zoneQ;
  logic [DW-1:0]    addrQ;
  logic [DW-1:0]    tagArr  [ENTRIES];
  logic [DW-1:0]    dataArr [ENTRIES];
  logic [TID_W-1:0] tidArr  [ENTRIES];
  logic [IDX_W-1:0] entSel;
  logic             pidChg;
  logic [DW-1:0]    rdMux;

  assign entSel   = idxQ[IDX_W-1:0];
  assign pidChg   = wrData[TID_W-1:0] != pidQ;
  assign indexQ   = idxQ;
  assign pidOut   = pidQ;
  assign zoneOut  = zoneQ;
  assign srchAddr = addrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ  <= '0;
      pidQ  <= '0;
      zoneQ <= '0;
      addrQ <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tagArr[e]  <= '0;
        dataArr[e] <= '0;
        tidArr[e]  <= '0;
      end
    end else begin
      if (strb.idxWr) idxQ[DW-2:0] <= wrData[DW-2:0];
      if (strb.srchEnd) begin
        if (srchHit) idxQ <= {{(DW-IDX_W){1'b0}}, srchIdx};
        else idxQ[DW-1] <= 1'b1;
      end
      if (strb.pidWr) pidQ <= wrData[TID_W-1:0];
      if (strb.tagRd) pidQ <= tidArr[entSel];
      if (strb.zoneWr) zoneQ <= wrData;
      if (strb.tagWr) begin
        tagArr[entSel] <= wrData;
        tidArr[entSel] <= pidQ;
      end
      if (strb.dataWr) dataArr[entSel] <= wrData;
      if (strb.srchGo) addrQ <= wrData & PAGE_MASK;
    end
  end

  always_comb begin
    rdMux = '0;
    case (regSel)
      SEL_INDEX: rdMux = idxQ;
      SEL_PID:   rdMux[TID_W-1:0] = pidQ;
      SEL_ZONE:  rdMux = zoneQ;
      SEL_TAG:   rdMux = tagArr[entSel];
      SEL_DATA:  rdMux = dataArr[entSel];
      default: ;
    endcase
    rdData = strb.rdOk ? rdMux : '0;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic entValid;
    logic tagHit;
    logic pidHit;
    assign entValid = tagArr[e][VALID_BIT];
    assign tagHit   = strb.tagWr && (entSel == IDX_W'(e));
    assign pidHit   = strb.pidWr && pidChg && (tidArr[e] != '0) && (tidArr[e] == pidQ);
    assign invalMask[e] = entValid & (tagHit | pidHit);
    assign tagFlat[e*DW +: DW]        = tagArr[e];
    assign dataFlat[e*DW +: DW]       = dataArr[e];
    assign tidFlat[e*TID_W +: TID_W]  = tidArr[e];
  end
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int TID_W     = 8,
  parameter int PAGE_LSB  = 10,
  parameter int VALID_BIT = 6,
  parameter int ACCESS    = 3,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [2:0]               regSel,
  input  logic [31:0]              wrData,
  output logic [31:0]              rdData,
  output logic                     ready,
  output logic                     srchReq,
  output logic [31:0]              srchAddr,
  input  logic                     srchDone,
  input  logic                     srchHit,
  input  logic [IDX_W-1:0]         srchIdx,
  output logic [ENTRIES-1:0]       invalMask,
  output logic [TID_W-1:0]         pidOut,
  output logic [31:0]              zoneOut,
  output logic [ENTRIES*32-1:0]    tagFlat,
  output logic [ENTRIES*32-1:0]    dataFlat,
  output logic [ENTRIES*TID_W-1:0] tidFlat
);
  strobes_t      strb;
  logic [DW-1:0] indexQ;

  tlb_mgmt_ctrl #(.ACCESS(ACCESS)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .srchDone(srchDone), .ready(ready), .pending(srchReq), .strb(strb)
  );

  tlb_mgmt_dp #(
    .ENTRIES(ENTRIES), .TID_W(TID_W), .PAGE_LSB(PAGE_LSB), .VALID_BIT(VALID_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .regSel(regSel), .wrData(wrData),
    .srchHit(srchHit), .srchIdx(srchIdx), .rdData(rdData), .srchAddr(srchAddr),
    .indexQ(indexQ), .invalMask(invalMask), .pidOut(pidOut), .zoneOut(zoneOut),
    .tagFlat(tagFlat), .dataFlat(dataFlat), .tidFlat(tidFlat)
  );
endmodule

// File: rtl/tlb_mgmt_chk.sv
module tlb_mgmt_chk #(
  parameter int ENTRIES = 16,
  parameter int ACCESS  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic               rdEn,
  input logic [2:0]         regSel,
  input logic [31:0]        rdData,
  input logic               ready,
  input logic               srchReq,
  input logic [31:0]        srchAddr,
  input logic               srchDone,
  input logic               srchHit,
  input logic [IDX_W-1:0]   srchIdx,
  input logic [ENTRIES-1:0] invalMask,
  input logic [31:0]        indexQ
);
  localparam bit FULL_OK = (ACCESS & 2) != 0;

  assert_search_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (FULL_OK && ready && wrEn && regSel == 3'd5) |=> (srchReq && !ready));

  assert_search_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (srchReq && !srchDone) |=> (srchReq && $stable(srchAddr)));

  assert_miss_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (srchReq && srchDone && !srchHit) |=>
      (indexQ[31] && indexQ[30:0] == $past(indexQ[30:0])));

  assert_hit_index_R8: assert property (@(posedge clk) disable iff (rst)
    (srchReq && srchDone && srchHit) |=> (indexQ == 32'($past(srchIdx))));

  assert_flag_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && wrEn && regSel == 3'd0) |=> (indexQ[31] == $past(indexQ[31])));

  assert_single_inval_R5: assert property (@(posedge clk) disable iff (rst)
    (ready && wrEn && regSel == 3'd3) |-> $onehot0(invalMask));

  assert_quiet_inval_R11: assert property (@(posedge clk) disable iff (rst)
    !(ready && wrEn && (regSel == 3'd3 || regSel == 3'd1)) |-> (invalMask == '0));

  assert_search_rd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && rdEn && !wrEn && regSel >= 3'd5) |-> (rdData == '0));
endmodule

bind tlb_mgmt_regs tlb_mgmt_chk #(.ENTRIES(ENTRIES), .ACCESS(ACCESS)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
  .rdData(rdData), .ready(ready), .srchReq(srchReq), .srchAddr(srchAddr),
  .srchDone(srchDone), .srchHit(srchHit), .srchIdx(srchIdx),
  .invalMask(invalMask), .indexQ(indexQ)
);

// File: tb/test_tlb_mgmt_regs.sv
`timescale 1ns/1ps
module test_tlb_mgmt_regs;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] wrData = '0;
  logic srchDone = 1'b0, srchHit = 1'b0;
  logic [IW-1:0] srchIdx = '0;

  logic [31:0] rdData, srchAddr, zoneOut;
  logic ready, srchReq;
  logic [N-1:0] invalMask;
  logic [7:0] pidOut;
  logic [N*32-1:0] tagFlat, dataFlat;
  logic [N*8-1:0] tidFlat;

  logic [31:0] roRd, roAddr, roZone;
  logic roReady, roReq;
  logic [N-1:0] roInval;
  logic [7:0] roPid;
  logic [N*32-1:0] roTag, roData;
  logic [N*8-1:0] roTid;

  logic [31:0] woRd, woAddr, woZone;
  logic woReady, woReq;
  logic [N-1:0] woInval;
  logic [7:0] woPid;
  logic [N*32-1:0] woTag, woData;
  logic [N*8-1:0] woTid;

  always #10 clk = ~clk;

  tlb_mgmt_regs i_tlb_mgmt_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .ready(ready), .srchReq(srchReq), .srchAddr(srchAddr),
    .srchDone(srchDone), .srchHit(srchHit), .srchIdx(srchIdx), .invalMask(invalMask),
    .pidOut(pidOut), .zoneOut(zoneOut), .tagFlat(tagFlat), .dataFlat(dataFlat), .tidFlat(tidFlat));

  tlb_mgmt_regs #(.ACCESS(1)) i_tlb_mgmt_regs_ro (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel), .wrData(wrData),
    .rdData(roRd), .ready(roReady), .srchReq(roReq), .srchAddr(roAddr),
    .srchDone(srchDone), .srchHit(srchHit), .srchIdx(srchIdx), .invalMask(roInval),
    .pidOut(roPid), .zoneOut(roZone), .tagFlat(roTag), .dataFlat(roData), .tidFlat(roTid));

  tlb_mgmt_regs #(.ACCESS(2)) i_tlb_mgmt_regs_wo (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel), .wrData(wrData),
    .rdData(woRd), .ready(woReady), .srchReq(woReq), .srchAddr(woAddr),
    .srchDone(srchDone), .srchHit(srchHit), .srchIdx(srchIdx), .invalMask(woInval),
    .pidOut(woPid), .zoneOut(woZone), .tagFlat(woTag), .dataFlat(woData), .tidFlat(woTid));

  int nChecks = 0;
  int nFails = 0;

  logic [31:0] expIdx = '0;
  logic [7:0]  expPid = '0;
  logic [31:0] expZone = '0;
  logic [31:0] expTag [N];
  logic [31:0] expData [N];
  logic [7:0]  expTid [N];
  logic [31:0] gotMain, gotRo, gotWo;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] sel);
    case (sel)
      3'd0: return expIdx;
      3'd1: return {24'd0, expPid};
      3'd2: return expZone;
      3'd3: return expTag[expIdx[3:0]];
      3'd4: return expData[expIdx[3:0]];
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] v);
    logic [N-1:0] em;
    int e;
    string rq;
    em = '0;
    e = int'(expIdx[3:0]);
    rq = (sel == 3'd3) ? "R5" : "R11";
    if (sel == 3'd3 && expTag[e][6]) em[e] = 1'b1;
    if (sel == 3'd1 && v[7:0] != expPid)
      for (int k = 0; k < N; k++)
        if (expTag[k][6] && expTid[k] != 0 && expTid[k] == expPid) em[k] = 1'b1;
    @(negedge clk);
    regSel = sel; wrData = v; wrEn = 1'b1;
    #1 check(invalMask == em, rq, 64'(invalMask), 64'(em));
    @(negedge clk);
    wrEn = 1'b0;
    case (sel)
      3'd0: expIdx[30:0] = v[30:0];
      3'd1: expPid = v[7:0];
      3'd2: expZone = v;
      3'd3: begin expTag[e] = v; expTid[e] = expPid; end
      3'd4: expData[e] = v;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] sel, input string req);
    logic [31:0] ev;
    ev = expRead(sel);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 begin gotMain = rdData; gotRo = roRd; gotWo = woRd; end
    check(gotMain == ev, req, 64'(gotMain), 64'(ev));
    check(invalMask == '0, "R11", 64'(invalMask), 64'd0);
    @(negedge clk);
    rdEn = 1'b0;
    if (sel == 3'd3) expPid = expTid[expIdx[3:0]];
  endtask

  task automatic doSearch(input logic [31:0] v, input int lat, input bit hit, input logic [IW-1:0] hidx);
    wr(3'd5, v);
    check(ready == 1'b0, "R7", 64'(ready), 64'd0);
    check(srchReq == 1'b1, "R7", 64'(srchReq), 64'd1);
    check(srchAddr == {v[31:10], 10'd0}, "R7", 64'(srchAddr), 64'({v[31:10], 10'd0}));
    check(roReady == 1'b1 && roReq == 1'b0, "R10", 64'({roReady, roReq}), 64'b10);
    for (int c = 0; c < lat; c++) begin
      @(negedge clk);
      check(ready == 1'b0, "R7", 64'(ready), 64'd0);
    end
    srchDone = 1'b1; srchHit = hit; srchIdx = hidx;
    @(negedge clk);
    srchDone = 1'b0; srchHit = 1'b0; srchIdx = '0;
    check(ready == 1'b1 && srchReq == 1'b0, "R7", 64'({ready, srchReq}), 64'b10);
    if (hit) expIdx = {28'd0, hidx};
    else expIdx[31] = 1'b1;
    rd(3'd0, "R8");
  endtask

  task automatic t_reset;
    check(ready == 1'b1 && srchReq == 1'b0, "R1", 64'({ready, srchReq}), 64'b10);
    check(invalMask == '0, "R1", 64'(invalMask), 64'd0);
    for (int s = 0; s < 8; s++) rd(3'(s), "R1");
  endtask

  task automatic t_index;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, "R2");
    wr(3'd0, 32'h0000_0003);
    rd(3'd0, "R2");
  endtask

  task automatic t_window;
    wr(3'd1, 32'h0000_01A5);
    rd(3'd1, "R4");
    wr(3'd3, 32'h1234_5440);
    wr(3'd4, 32'hAAAA_0005);
    rd(3'd3, "R3");
    rd(3'd4, "R3");
    check(tidFlat[3*8 +: 8] == 8'hA5, "R4", 64'(tidFlat[3*8 +: 8]), 64'hA5);
    wr(3'd1, 32'd0);
    rd(3'd3, "R6");
    rd(3'd1, "R6");
    wr(3'd3, 32'h1234_5441);
    wr(3'd0, 32'h0000_0013);
    rd(3'd3, "R2");
  endtask

  task automatic t_pid;
    wr(3'd1, 32'h22);
    wr(3'd0, 32'd5); wr(3'd3, 32'h0000_1040);
    wr(3'd0, 32'd6); wr(3'd3, 32'h0000_2000);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd7); wr(3'd3, 32'h0000_3040);
    wr(3'd1, 32'h22);
    wr(3'd1, 32'h22);
    wr(3'd1, 32'h77);
    wr(3'd0, 32'd6); wr(3'd3, 32'h0000_2040);
    rd(3'd1, "R11");
  endtask

  task automatic t_search;
    doSearch(32'h0000_57FF, 2, 1'b0, 4'd0);
    rd(3'd0, "R10");
    check(gotRo[31] == 1'b0, "R10", 64'(gotRo), 64'(expIdx & 32'h7FFF_FFFF));
    wr(3'd0, 32'h0000_0002);
    rd(3'd0, "R2");
    doSearch(32'h1234_57FF, 4, 1'b1, 4'd9);
  endtask

  task automatic t_misc;
    rd(3'd5, "R9");
    wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd6, "R9");
    rd(3'd7, "R9");
    rd(3'd0, "R9");
    rd(3'd1, "R9");
  endtask

  task automatic t_zone;
    wr(3'd2, 32'hC3C3_0F0F);
    rd(3'd2, "R12");
    check(zoneOut == 32'hC3C3_0F0F, "R12", 64'(zoneOut), 64'hC3C3_0F0F);
  endtask

  task automatic t_access;
    rd(3'd2, "R12");
    check(gotRo == 32'd0, "R10", 64'(gotRo), 64'd0);
    check(gotWo == 32'd0, "R10", 64'(gotWo), 64'd0);
    rd(3'd1, "R4");
    check(gotRo == 32'd0, "R10", 64'(gotRo), 64'd0);
    check(gotWo == 32'd0, "R10", 64'(gotWo), 64'd0);
    check(woPid == expPid, "R10", 64'(woPid), 64'(expPid));
    rd(3'd0, "R2");
    check(gotWo == expIdx, "R10", 64'(gotWo), 64'(expIdx));
    wr(3'd0, 32'd3);
    rd(3'd4, "R3");
    check(gotRo == 32'hAAAA_0005, "R10", 64'(gotRo), 64'hAAAA_0005);
    check(gotWo == 32'd0, "R10", 64'(gotWo), 64'd0);
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      expTag[k] = '0; expData[k] = '0; expTid[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_index();
    t_window();
    t_pid();
    t_search();
    t_misc();
    t_zone();
    t_access();
    finishRun();
  end
endmodule